// File: doc/BRIEF.md
# Serial Bus Test-Mode and Status Controller

This block is the register-side control logic of a two-wire serial bus controller. Software selects one of four test modes, and the block decides what pulls the clock and data pads low in each mode. In functional mode the pads follow the protocol engine. In the clock test mode a prescaler and two phase counters drive a free-running clock on the clock pad, as a bus master would. In the loop-and-direct-I/O mode a master-transmit byte goes back into the receive side of the data register through one-deep transmit and receive buffers. In that same mode, with system test enabled, software drives both pads directly and reads back the synchronised level of the clock line.

Six status flags are cleared by writing ones. A set-all control forces every flag to 1 for as long as it is held, and while it is held, clear writes have no effect. The protocol engine sets flags with one-cycle event pulses. An interrupt line and a receive DMA request are derived from the flags and from the receive buffer.

Register addresses: 0 control, 1 status, 2 prescaler, 3 low count, 4 high count, 5 data, 6 pad test, 7 interrupt mask. Control bits: [1:0] mode (00 functional, 01 reserved, 10 clock test, 11 loop/direct I/O), [2] system-test enable, [3] set-all, [4] master, [5] transmit, [6] DMA enable. Reads are combinational and return zero above each register's width.

Top module: `sbus_testctl`

## Requirements
- R1: After reset the control, status, data and pad-test registers read 0, `irq` and `dma_rx_req` are 0, and with idle engine inputs both pad pull-downs are 0.
- R2: In mode 00 and in mode 01, `scl_drv_low` follows `eng_scl_low` and `sda_drv_low` follows `eng_sda_low`.
- R3: In mode 10 with prescaler P, low count L and high count H, `scl_drv_low` is 1 for (P+1)*(L+1) cycles and then 0 for (P+1)*(H+1) cycles, repeating. The low phase starts on the first cycle after mode 10 is written. `sda_drv_low` is 0 throughout. Leaving mode 10 stops the generator.
- R4: In mode 11 with system-test enable set, pad-test bit 0 is the clock level, bit 1 the clock enable, bit 2 the data level and bit 3 the data enable. A pad is pulled low when its enable is 1 and its level is 0. In mode 11 with system-test enable clear, both pads are released.
- R5: Pad-test read bit 4 returns `scl_in` through a two-flop synchroniser when the mode is 11 and system-test enable is set. Otherwise it reads 0.
- R6: In mode 11 with master and transmit both set, a byte written to the data register reads back from the data register one cycle later and sets status bit 3. Without loopback, a data write fills the transmit buffer only.
- R7: `irq` is the OR of status flags ANDed with the mask register. `dma_rx_req` is 1 while the DMA enable is set and an unread received byte is held. Reading the data register clears `dma_rx_req`.
- R8: Writing control with bit 3 = 1 forces all six status flags to 1 on that same edge, and on every edge while the bit stays 1.
- R9: Writing 1 to a status bit clears it only while set-all is 0. Writing set-all to 0 leaves the flags unchanged. A status flag never falls without such a write.
- R10: An `evt_set` pulse sets the matching flag. When an event and a clear of the same flag arrive on the same cycle, the flag ends up set.
- R11: Outside loopback, `eng_tx_take` empties the transmit buffer (`tx_full` falls). An `eng_rx_valid` pulse loads `eng_rx_byte` into the receive buffer, sets status bit 3 and makes the byte readable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (side effect on data register only) |
| addr | input | AW | Register address |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data, combinational |
| evt_set | input | NF | Status-set pulses from the protocol engine |
| eng_scl_low | input | 1 | Engine request to pull the clock pad low |
| eng_sda_low | input | 1 | Engine request to pull the data pad low |
| eng_tx_take | input | 1 | Engine consumed the transmit byte |
| eng_rx_valid | input | 1 | Engine delivers a received byte |
| eng_rx_byte | input | BW | Byte received by the engine |
| tx_byte | output | BW | Transmit buffer contents |
| tx_full | output | 1 | Transmit buffer holds a byte |
| scl_in | input | 1 | Sensed clock line level (asynchronous) |
| scl_drv_low | output | 1 | Pull clock pad low (0 = release) |
| sda_drv_low | output | 1 | Pull data pad low (0 = release) |
| irq | output | 1 | Interrupt request |
| dma_rx_req | output | 1 | Receive DMA request |

## Verification
The bench goes after the interlock between set-all and ones-to-clear writes. It issues clears while set-all is held, releases it, and then clears single flags; a design that honoured clears during set-all, or that cleared flags when set-all was dropped, would read back the wrong status word. It also lands an event and a clear on the same flag in one cycle, which catches a design that gives the clear priority. The clock generator is sampled cycle by cycle over more than one full period, so an off-by-one in the prescaler or in either phase length shifts a transition and shows up. The loopback latency, the two-stage sense latency and the zeroing of the sense bit outside the system-test mode are each checked at the exact cycle where a wrong design would differ.

// File: rtl/sbus_pkg.sv
package sbus_pkg;

  typedef enum logic [1:0] {
    TM_FUNC   = 2'b00,
    TM_RSVD   = 2'b01,
    TM_SCLGEN = 2'b10,
    TM_LOOPIO = 2'b11
  } tmode_e;

  typedef struct packed {
    logic   dma_en;
    logic   xmit;
    logic   master;
    logic   set_all;
    logic   st_en;
    tmode_e mode;
  } ctrl_t;

  localparam int CTRL_W  = $bits(ctrl_t);
  localparam int PADT_W  = 4;
  localparam int RX_FLAG = 3;

  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_STAT = 3'd1;
  localparam logic [2:0] A_PSC  = 3'd2;
  localparam logic [2:0] A_LOW  = 3'd3;
  localparam logic [2:0] A_HIGH = 3'd4;
  localparam logic [2:0] A_DATA = 3'd5;
  localparam logic [2:0] A_PADT = 3'd6;
  localparam logic [2:0] A_MASK = 3'd7;

endpackage

// File: rtl/sbus_sync2.sv
module sbus_sync2 #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);

  logic stage1;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage1 <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end

endmodule

// File: rtl/sbus_sclgen.sv
module sbus_sclgen #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] psc,
  input  logic [CW-1:0] lo_cnt,
  input  logic [CW-1:0] hi_cnt,
  output logic          scl_low
);

  logic [CW-1:0] pre_q, pre_nx;
  logic [CW-1:0] ph_q, ph_nx;
  logic          hi_q, hi_nx;
  logic          tick;
  logic [CW-1:0] limit;
  logic          upd;

  assign tick  = (pre_q == psc);
  assign limit = hi_q ? hi_cnt : lo_cnt;
  assign upd   = run | hi_q | (pre_q != '0) | (ph_q != '0);

  always_comb begin
    pre_nx = '0;
    ph_nx  = '0;
    hi_nx  = 1'b0;
    if (run) begin
      pre_nx = tick ? '0 : pre_q + CW'(1);
      ph_nx  = ph_q;
      hi_nx  = hi_q;
      if (tick) begin
        if (ph_q == limit) begin
          ph_nx = '0;
          hi_nx = ~hi_q;
        end else begin
          ph_nx = ph_q + CW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      ph_q  <= '0;
      hi_q  <= 1'b0;
    end else if (upd) begin
      pre_q <= pre_nx;
      ph_q  <= ph_nx;
      hi_q  <= hi_nx;
    end
  end

  assign scl_low = run & ~hi_q;

endmodule

// File: rtl/sbus_loopbk.sv
module sbus_loopbk #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lb_en,
  input  logic          wr_data,
  input  logic [BW-1:0] wbyte,
  input  logic          rd_data,
  input  logic          eng_tx_take,
  input  logic          eng_rx_valid,
  input  logic [BW-1:0] eng_rx_byte,
  output logic [BW-1:0] tx_byte,
  output logic          tx_full,
  output logic [BW-1:0] rx_byte,
  output logic          rx_full,
  output logic          rx_load
);

  logic          move;
  logic          eng_load;
  logic          txf_nx, rxf_nx;
  logic [BW-1:0] rx_nx;

  assign move     = lb_en & tx_full;
  assign eng_load = eng_rx_valid & ~lb_en;
  assign rx_load  = move | eng_load;

  always_comb begin
    txf_nx = tx_full;
    if (wr_data)                           txf_nx = 1'b1;
    else if (move | (eng_tx_take & ~lb_en)) txf_nx = 1'b0;

    rx_nx = move ? tx_byte : eng_rx_byte;

    rxf_nx = rx_full;
    if (rx_load)      rxf_nx = 1'b1;
    else if (rd_data) rxf_nx = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_byte <= '0;
      tx_full <= 1'b0;
      rx_byte <= '0;
      rx_full <= 1'b0;
    end else begin
      if (wr_data) tx_byte <= wbyte;
      if (rx_load) rx_byte <= rx_nx;
      tx_full <= txf_nx;
      rx_full <= rxf_nx;
    end
  end

endmodule

// File: rtl/sbus_testctl.sv
module sbus_testctl
  import sbus_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 3,
  parameter int BW = 8,
  parameter int CW = 8,
  parameter int NF = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [NF-1:0] evt_set,
  input  logic          eng_scl_low,
  input  logic          eng_sda_low,
  input  logic          eng_tx_take,
  input  logic          eng_rx_valid,
  input  logic [BW-1:0] eng_rx_byte,
  output logic [BW-1:0] tx_byte,
  output logic          tx_full,
  input  logic          scl_in,
  output logic          scl_drv_low,
  output logic          sda_drv_low,
  output logic          irq,
  output logic          dma_rx_req
);

  logic rst_sync_n;

  sbus_sync2 #(.RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .arst_n(rst_n), .d(1'b1), .q(rst_sync_n)
  );

  // register state
  ctrl_t             ctrl_q, ctrl_nx;
  logic [NF-1:0]     flags_q, flags_nx;
  logic [NF-1:0]     mask_q;
  logic [CW-1:0]     psc_q, lo_q, hi_q;
  logic [PADT_W-1:0] padt_q;

  logic wr_ctrl, wr_stat, wr_psc, wr_low, wr_high, wr_data, wr_padt, wr_mask;
  logic rd_data;

  assign wr_ctrl = wr_en & (addr == AW'(A_CTRL));
  assign wr_stat = wr_en & (addr == AW'(A_STAT));
  assign wr_psc  = wr_en & (addr == AW'(A_PSC));
  assign wr_low  = wr_en & (addr == AW'(A_LOW));
  assign wr_high = wr_en & (addr == AW'(A_HIGH));
  assign wr_data = wr_en & (addr == AW'(A_DATA));
  assign wr_padt = wr_en & (addr == AW'(A_PADT));
  assign wr_mask = wr_en & (addr == AW'(A_MASK));
  assign rd_data = rd_en & (addr == AW'(A_DATA));

  logic unused_wdata;
  assign unused_wdata = ^wdata;

  // datapath submodules
  logic          lb_en, gen_run, gen_scl_low;
  logic [BW-1:0] rx_byte;
  logic          rx_full, rx_load;
  logic          scl_sync;

  assign lb_en   = (ctrl_q.mode == TM_LOOPIO) & ctrl_q.master & ctrl_q.xmit;
  assign gen_run = (ctrl_q.mode == TM_SCLGEN);

  sbus_sclgen #(.CW(CW)) u_sclgen (
    .clk(clk), .rst_n(rst_sync_n), .run(gen_run),
    .psc(psc_q), .lo_cnt(lo_q), .hi_cnt(hi_q), .scl_low(gen_scl_low)
  );

  sbus_loopbk #(.BW(BW)) u_loopbk (
    .clk(clk), .rst_n(rst_sync_n), .lb_en(lb_en),
    .wr_data(wr_data), .wbyte(wdata[BW-1:0]), .rd_data(rd_data),
    .eng_tx_take(eng_tx_take), .eng_rx_valid(eng_rx_valid),
    .eng_rx_byte(eng_rx_byte), .tx_byte(tx_byte), .tx_full(tx_full),
    .rx_byte(rx_byte), .rx_full(rx_full), .rx_load(rx_load)
  );

  sbus_sync2 #(.RST_VAL(1'b0)) u_scl_sync (
    .clk(clk), .arst_n(rst_sync_n), .d(scl_in), .q(scl_sync)
  );

  // status next state: set-all beats events, events beat clears
  logic          force_all;
  logic [NF-1:0] clr_vec, set_vec;

  assign force_all = ctrl_q.set_all | (wr_ctrl & wdata[3]);
  assign clr_vec   = (wr_stat & ~ctrl_q.set_all) ? wdata[NF-1:0] : '0;

  always_comb begin
    set_vec          = evt_set;
    set_vec[RX_FLAG] = evt_set[RX_FLAG] | rx_load;
    flags_nx         = force_all ? '1 : ((flags_q & ~clr_vec) | set_vec);
    ctrl_nx          = ctrl_t'(wdata[CTRL_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ctrl_q  <= '0;
      flags_q <= '0;
      mask_q  <= '0;
      psc_q   <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
      padt_q  <= '0;
    end else begin
      flags_q <= flags_nx;
      if (wr_ctrl) ctrl_q <= ctrl_nx;
      if (wr_mask) mask_q <= wdata[NF-1:0];
      if (wr_psc)  psc_q  <= wdata[CW-1:0];
      if (wr_low)  lo_q   <= wdata[CW-1:0];
      if (wr_high) hi_q   <= wdata[CW-1:0];
      if (wr_padt) padt_q <= wdata[PADT_W-1:0];
    end
  end

  // pad selection
  logic io_mode, scl_sense;
  assign io_mode   = (ctrl_q.mode == TM_LOOPIO) & ctrl_q.st_en;
  assign scl_sense = io_mode & scl_sync;

  always_comb begin
    scl_drv_low = 1'b0;
    sda_drv_low = 1'b0;
    unique case (ctrl_q.mode)
      TM_FUNC, TM_RSVD: begin
        scl_drv_low = eng_scl_low;
        sda_drv_low = eng_sda_low;
      end
      TM_SCLGEN: scl_drv_low = gen_scl_low;
      TM_LOOPIO: begin
        if (ctrl_q.st_en) begin
          scl_drv_low = padt_q[1] & ~padt_q[0];
          sda_drv_low = padt_q[3] & ~padt_q[2];
        end
      end
      default: ;
    endcase
  end

  // read mux
  always_comb begin
    rdata = '0;
    case (addr)
      AW'(A_CTRL): rdata = DW'(ctrl_q);
      AW'(A_STAT): rdata = DW'(flags_q);
      AW'(A_PSC):  rdata = DW'(psc_q);
      AW'(A_LOW):  rdata = DW'(lo_q);
      AW'(A_HIGH): rdata = DW'(hi_q);
      AW'(A_DATA): rdata = DW'(rx_byte);
      AW'(A_PADT): rdata = DW'({scl_sense, padt_q});
      AW'(A_MASK): rdata = DW'(mask_q);
      default:     rdata = '0;
    endcase
  end

  assign irq        = |(flags_q & mask_q);
  assign dma_rx_req = ctrl_q.dma_en & rx_full;

endmodule

// File: rtl/sbus_testctl_chk.sv
module sbus_testctl_chk
  import sbus_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 3,
  parameter int NF = 6
) (
  input logic          clk,
  input logic          rst_sync_n,
  input ctrl_t         ctrl_q,
  input logic [NF-1:0] flags_q,
  input logic          wr_en,
  input logic [AW-1:0] addr,
  input logic [NF-1:0] evt_set,
  input logic          scl_drv_low,
  input logic          sda_drv_low,
  input logic          eng_scl_low,
  input logic          eng_sda_low,
  input logic          lb_en,
  input logic          tx_full,
  input logic          rx_full,
  input logic [DW-1:0] rdata
);

  AST_SETALL_FORCES: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ctrl_q.set_all |=> (flags_q == '1)); // R8

  AST_NO_SILENT_CLEAR: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(wr_en && addr == AW'(A_STAT)) |=> ((flags_q & $past(flags_q)) == $past(flags_q))); // R9

  AST_EVENT_STICKS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (evt_set != '0) |=> ((flags_q & $past(evt_set)) == $past(evt_set))); // R10

  AST_FUNC_PADS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ctrl_q.mode == TM_FUNC) |-> (scl_drv_low == eng_scl_low && sda_drv_low == eng_sda_low)); // R2

  AST_GEN_SDA_IDLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ctrl_q.mode == TM_SCLGEN) |-> !sda_drv_low); // R3

  AST_LOOP_MOVES: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (lb_en && tx_full) |=> rx_full); // R6

  AST_SENSE_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!ctrl_q.st_en && addr == AW'(A_PADT)) |-> (rdata[4] == 1'b0)); // R5

endmodule

bind sbus_testctl sbus_testctl_chk #(.DW(DW), .AW(AW), .NF(NF)) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .ctrl_q(ctrl_q), .flags_q(flags_q),
  .wr_en(wr_en), .addr(addr), .evt_set(evt_set),
  .scl_drv_low(scl_drv_low), .sda_drv_low(sda_drv_low),
  .eng_scl_low(eng_scl_low), .eng_sda_low(eng_sda_low),
  .lb_en(lb_en), .tx_full(tx_full), .rx_full(rx_full), .rdata(rdata)
);

// File: tb/sbus_testctl_test.sv
`timescale 1ns/1ps
module sbus_testctl_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, rd_en;
  logic [2:0]  addr;
  logic [15:0] wdata, rdata;
  logic [5:0]  evt_set;
  logic        eng_scl_low, eng_sda_low, eng_tx_take, eng_rx_valid;
  logic [7:0]  eng_rx_byte, tx_byte;
  logic        tx_full, scl_in, scl_drv_low, sda_drv_low, irq, dma_rx_req;

  always #10 clk = ~clk;

  sbus_testctl uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .evt_set(evt_set),
    .eng_scl_low(eng_scl_low), .eng_sda_low(eng_sda_low),
    .eng_tx_take(eng_tx_take), .eng_rx_valid(eng_rx_valid),
    .eng_rx_byte(eng_rx_byte), .tx_byte(tx_byte), .tx_full(tx_full),
    .scl_in(scl_in), .scl_drv_low(scl_drv_low), .sda_drv_low(sda_drv_low),
    .irq(irq), .dma_rx_req(dma_rx_req)
  );

  // kinds: 0 read data, 1 {sda,scl} pull-downs, 2 {dma,irq}, 3 {tx_full,tx_byte}
  typedef struct {
    int          kind;
    logic [15:0] exp;
    string       tag;
  } item_t;

  item_t       sb[$];
  logic        pon = 1'b0;
  int          n_vec = 0;
  int          n_bad = 0;
  bit          done = 0;

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic push(input int k, input logic [15:0] e, input string t);
    item_t it;
    it.kind = k; it.exp = e; it.tag = t;
    sb.push_back(it);
  endtask

  task automatic rd(input logic [2:0] a, input logic [15:0] e, input string t);
    addr = a; rd_en = 1'b1; pon = 1'b1;
    push(0, e, t);
    @(negedge clk);
    rd_en = 1'b0; pon = 1'b0;
  endtask

  task automatic probe(input int k, input logic [15:0] e, input string t);
    pon = 1'b1;
    push(k, e, t);
    @(negedge clk);
    pon = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (pon && sb.size() > 0) begin
        item_t it;
        logic [15:0] got;
        it = sb.pop_front();
        case (it.kind)
          0:       got = rdata;
          1:       got = {14'b0, sda_drv_low, scl_drv_low};
          2:       got = {14'b0, dma_rx_req, irq};
          default: got = {7'b0, tx_full, tx_byte};
        endcase
        n_vec++;
        if (got !== it.exp) begin
          n_bad++;
          $display("FAIL %s: got %h expected %h", it.tag, got, it.exp);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    evt_set = '0; eng_scl_low = 1'b0; eng_sda_low = 1'b0;
    eng_tx_take = 1'b0; eng_rx_valid = 1'b0; eng_rx_byte = '0; scl_in = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(3);

    // R1 reset state
    rd(3'd0, 16'h0000, "R1 control");
    rd(3'd1, 16'h0000, "R1 status");
    rd(3'd6, 16'h0000, "R1 pad test");
    rd(3'd5, 16'h0000, "R1 data");
    probe(1, 16'h0, "R1 pads released");
    probe(2, 16'h0, "R1 irq dma");

    // R2 functional and reserved modes follow the engine
    eng_scl_low = 1'b1;
    probe(1, 16'h1, "R2 mode00 scl");
    wr(3'd0, 16'h0001);
    eng_sda_low = 1'b1;
    probe(1, 16'h3, "R2 mode01 both");
    eng_scl_low = 1'b0; eng_sda_low = 1'b0;
    wr(3'd0, 16'h0000);

    // R3 clock generator: P=1 L=2 H=1 -> 6 low, 4 high
    wr(3'd2, 16'd1);
    wr(3'd3, 16'd2);
    wr(3'd4, 16'd1);
    rd(3'd3, 16'd2, "R3 low count readback");
    wr(3'd0, 16'h0002);
    for (int i = 1; i <= 12; i++) begin
      probe(1, ((i <= 6) || (i >= 11)) ? 16'h1 : 16'h0, "R3 clock waveform");
    end
    wr(3'd0, 16'h0000);
    probe(1, 16'h0, "R3 generator stops");

    // R10 / R9 / R8 status interlock
    evt_set = 6'h01; @(negedge clk); evt_set = '0;
    rd(3'd1, 16'h0001, "R10 event sets flag");
    wr(3'd1, 16'h0001);
    rd(3'd1, 16'h0000, "R9 ones clear");
    wr(3'd0, 16'h0008);
    rd(3'd1, 16'h003F, "R8 set-all forces");
    rd(3'd0, 16'h0008, "R8 control readback");
    wr(3'd1, 16'h003F);
    rd(3'd1, 16'h003F, "R9 clear ignored under set-all");
    wr(3'd0, 16'h0000);
    rd(3'd1, 16'h003F, "R9 dropping set-all keeps flags");
    wr(3'd1, 16'h0005);
    rd(3'd1, 16'h003A, "R9 selective clear");
    evt_set = 6'h02;
    wr(3'd1, 16'h0002);
    evt_set = '0;
    rd(3'd1, 16'h003A, "R10 event beats clear");
    wr(3'd1, 16'h0002);
    rd(3'd1, 16'h0038, "R9 clear after event");
    wr(3'd1, 16'h0038);
    rd(3'd1, 16'h0000, "R9 all cleared");

    // R6 / R7 loopback
    wr(3'd7, 16'h0008);
    wr(3'd0, 16'h0073);
    wr(3'd5, 16'h00A5);
    probe(2, 16'h0, "R6 one cycle latency");
    probe(2, 16'h3, "R7 irq and dma raised");
    rd(3'd1, 16'h0008, "R6 rx flag");
    rd(3'd5, 16'h00A5, "R6 looped byte");
    probe(2, 16'h1, "R7 read clears dma");
    probe(3, 16'h00A5, "R6 tx buffer emptied");
    wr(3'd7, 16'h0000);
    probe(2, 16'h0, "R7 mask off");
    wr(3'd1, 16'h0008);
    wr(3'd0, 16'h0043);
    wr(3'd5, 16'h003C);
    idle(2);
    probe(3, 16'h013C, "R6 no loop without master transmit");
    rd(3'd1, 16'h0000, "R6 no rx flag");
    rd(3'd5, 16'h00A5, "R6 data unchanged");

    // R11 engine side
    wr(3'd0, 16'h0040);
    eng_tx_take = 1'b1; @(negedge clk); eng_tx_take = 1'b0;
    probe(3, 16'h003C, "R11 tx taken");
    eng_rx_byte = 8'h5A; eng_rx_valid = 1'b1; @(negedge clk); eng_rx_valid = 1'b0;
    probe(2, 16'h2, "R11 dma on engine byte");
    rd(3'd1, 16'h0008, "R11 rx flag");
    rd(3'd5, 16'h005A, "R11 engine byte");

    // R4 / R5 direct pad control and sense
    scl_in = 1'b1;
    wr(3'd0, 16'h0007);
    wr(3'd6, 16'h000A);
    probe(1, 16'h3, "R4 both pulled");
    wr(3'd6, 16'h000B);
    probe(1, 16'h2, "R4 sda pulled only");
    rd(3'd6, 16'h001B, "R5 sense high");
    wr(3'd0, 16'h0003);
    probe(1, 16'h0, "R4 released without st enable");
    rd(3'd6, 16'h000B, "R5 zero without st enable");
    wr(3'd0, 16'h0006);
    rd(3'd6, 16'h000B, "R5 zero in mode10");
    wr(3'd0, 16'h0007);
    scl_in = 1'b0;
    idle(1);
    rd(3'd6, 16'h001B, "R5 two stage latency");
    rd(3'd6, 16'h000B, "R5 sense low");
    wr(3'd0, 16'h0000);

    idle(2);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule